// File: doc/BRIEF.md
# SPI Slave Command Mailbox Front End

This block is the serial front end of a memory-mapped peripheral. A host drives a four-wire SPI bus in Mode 0 or Mode 3. The block oversamples the serial pins in the system clock domain and splits each frame into an instruction byte, a 16-bit address and data bytes. It then reads or writes a small internal byte memory, or it reports a status byte.

One address, the mailbox address 0xFE00, is steered away from ordinary memory. Bytes written there fill a command buffer that a processing engine reads through its own port. Bytes read there come from a separate response buffer that the engine fills. When a frame that loaded command bytes closes, the engine gets a single-cycle command-ready pulse. The engine reports back through a response-ready level, which the host sees in the status byte. Writes only take effect after a write-enable frame. An unrecognised instruction makes the block stay silent until chip select rises.

Top module: `spi_mailbox`

## Requirements
- R1: Mode 0 (SCK idle low) and Mode 3 (SCK idle high) frames both work: data written in one mode reads back correctly in the other.
- R2: SI is captured on SCK rising edges and SO changes only after SCK falling edges. Every byte is most significant bit first, so the first data bit is valid before the first rising edge of its byte.
- R3: so_oe is 0 while chip select is high and during the instruction and address bytes. It is 1 for every bit of a data byte returned by a read or status frame.
- R4: The recognised instruction codes are 0x02 (write), 0x03 (read), 0x05 (status) and 0x06 (write enable). Any other code keeps so_oe at 0 for the rest of the frame, and all later bytes of that frame are ignored.
- R5: Write and read are each followed by a 16-bit address, high byte first. The address increments after each data byte. Memory is indexed by the low MEM_AW address bits.
- R6: Data bytes of a write frame are stored only when the write-enable latch is set. The latch is set by a 0x06 frame and is cleared when any frame whose instruction was 0x02 ends.
- R7: The status byte has bit 0 = response-ready input and bit 1 = write-enable latch, with all other bits 0. It repeats for every further byte of the frame.
- R8: Write data at address 0xFE00 goes into the command buffer at a pointer that starts at 0 in each frame and advances per byte. Ordinary memory, including the location that aliases 0xFE00, is left unchanged.
- R9: cmd_ready pulses high for exactly one clock after chip select rises on a frame that stored at least one command byte. It never pulses for any other frame.
- R10: Read data at address 0xFE00 comes from the response buffer, starting at entry 0 in each frame and advancing per byte.
- R11: Chip select rising in the middle of a byte discards the partial byte and returns the decoder to expect a fresh instruction.
- R12: After reset, so_oe and cmd_ready are 0, the write-enable latch is clear and the decoder waits for an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the SO pad driver (0 = high impedance) |
| cmd_ready | output | 1 | One-cycle pulse: command buffer loaded |
| cmd_raddr | input | BUF_AW | Engine read address into the command buffer |
| cmd_rdata | output | 8 | Command buffer byte, one cycle after cmd_raddr |
| rsp_we | input | 1 | Engine write strobe into the response buffer |
| rsp_waddr | input | BUF_AW | Engine write address into the response buffer |
| rsp_wdata | input | 8 | Engine write data |
| rsp_ready | input | 1 | Engine level: response available, shown in status bit 0 |

## Verification
The hardest situation to reach is a frame cut off in the middle of a byte right after a write header. That case shows both that the partial byte never reaches memory and that the next frame is decoded from a clean bit count. The bench drives a write header followed by four stray bits, raises chip select, and reads the target back. It then sends three bits of an instruction, aborts, and requests status. The status value also shows that the aborted write frame cleared the write-enable latch. A second hard case is the mailbox alias: the bench first stores a known byte at the location that 0xFE00 aliases in ordinary memory, then loads the command buffer and reads that location back.

// File: rtl/spi_mailbox_pkg.sv
package spi_mailbox_pkg;

  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_WREN   = 8'h06;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WRITE,
    ST_READ,
    ST_STATUS,
    ST_HOLD,
    ST_MUTE
  } frame_state_t;

endpackage

// File: rtl/spi_mailbox_sync.sv
module spi_mailbox_sync #(
  parameter int          STAGES    = 2,
  parameter int          WIDTH     = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RESET_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_mailbox_ram.sv
module spi_mailbox_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_mailbox_shifter.sv
module spi_mailbox_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_s,
  input  logic       cs_n_s,
  input  logic       si_s,
  input  logic       tx_en,
  input  logic [7:0] tx_byte,
  output logic       byte_v,
  output logic [7:0] rx_byte,
  output logic       frame_end,
  output logic       so_d,
  output logic       so_oe
);

  logic       sck_q;
  logic       cs_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic       sck_rise;
  logic       sck_fall;

  assign sck_rise  = sck_s & ~sck_q & ~cs_n_s;
  assign sck_fall  = ~sck_s & sck_q & ~cs_n_s;
  assign frame_end = cs_n_s & ~cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      bit_cnt <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      byte_v  <= 1'b0;
      tx_sh   <= '0;
      so_d    <= 1'b0;
      so_oe   <= 1'b0;
    end else begin
      sck_q  <= sck_s;
      cs_q   <= cs_n_s;
      byte_v <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
        so_oe   <= 1'b0;
      end else begin
        if (sck_rise) begin
          bit_cnt <= bit_cnt + 3'd1;
          rx_sh   <= {rx_sh[5:0], si_s};
          if (bit_cnt == 3'd7) begin
            byte_v  <= 1'b1;
            rx_byte <= {rx_sh, si_s};
          end
        end
        if (sck_fall) begin
          if (bit_cnt == 3'd0) begin
            if (tx_en) begin
              so_d  <= tx_byte[7];
              tx_sh <= {tx_byte[6:0], 1'b0};
              so_oe <= 1'b1;
            end else begin
              so_oe <= 1'b0;
            end
          end else begin
            so_d  <= tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_mailbox.sv
module spi_mailbox
  import spi_mailbox_pkg::*;
#(
  parameter int          MEM_AW      = 8,
  parameter int          BUF_AW      = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] MBOX_ADDR   = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so_d,
  output logic              so_oe,
  output logic              cmd_ready,
  input  logic [BUF_AW-1:0] cmd_raddr,
  output logic [7:0]        cmd_rdata,
  input  logic              rsp_we,
  input  logic [BUF_AW-1:0] rsp_waddr,
  input  logic [7:0]        rsp_wdata,
  input  logic              rsp_ready
);

  localparam logic [BUF_AW-1:0] PTR_ONE = 1;

  logic [2:0]   pins_s;
  logic         sck_s, cs_n_s, si_s;
  logic         byte_v, frame_end, tx_en;
  logic [7:0]   rx_byte, tx_byte, status_byte, mem_q, rsp_q;
  frame_state_t state;
  logic [15:0]  addr;
  logic         mbox, wel, wr_frame, cmd_dirty, ld1, ld2;
  logic [BUF_AW-1:0] buf_ptr;
  logic         mem_we, cmd_we, wr_ok;

  spi_mailbox_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RESET_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sck, si}),
    .q   (pins_s)
  );

  assign cs_n_s = pins_s[2];
  assign sck_s  = pins_s[1];
  assign si_s   = pins_s[0];

  assign tx_en = (state == ST_READ) || (state == ST_STATUS);

  spi_mailbox_shifter u_shift (
    .clk       (clk),
    .rst       (rst),
    .sck_s     (sck_s),
    .cs_n_s    (cs_n_s),
    .si_s      (si_s),
    .tx_en     (tx_en),
    .tx_byte   (tx_byte),
    .byte_v    (byte_v),
    .rx_byte   (rx_byte),
    .frame_end (frame_end),
    .so_d      (so_d),
    .so_oe     (so_oe)
  );

  assign status_byte = {6'b0, wel, rsp_ready};
  assign wr_ok  = byte_v && (state == ST_WRITE) && wel;
  assign mem_we = wr_ok && !mbox;
  assign cmd_we = wr_ok && mbox;

  spi_mailbox_ram #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk (clk), .we (mem_we), .waddr (addr[MEM_AW-1:0]), .wdata (rx_byte),
    .raddr (addr[MEM_AW-1:0]), .rdata (mem_q)
  );

  spi_mailbox_ram #(.AW(BUF_AW), .DW(8)) u_cmd_buf (
    .clk (clk), .we (cmd_we), .waddr (buf_ptr), .wdata (rx_byte),
    .raddr (cmd_raddr), .rdata (cmd_rdata)
  );

  spi_mailbox_ram #(.AW(BUF_AW), .DW(8)) u_rsp_buf (
    .clk (clk), .we (rsp_we), .waddr (rsp_waddr), .wdata (rsp_wdata),
    .raddr (buf_ptr), .rdata (rsp_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OPCODE;
      addr      <= '0;
      mbox      <= 1'b0;
      buf_ptr   <= '0;
      wel       <= 1'b0;
      wr_frame  <= 1'b0;
      cmd_dirty <= 1'b0;
      cmd_ready <= 1'b0;
      ld1       <= 1'b0;
      ld2       <= 1'b0;
      tx_byte   <= '0;
    end else begin
      cmd_ready <= 1'b0;
      ld1       <= 1'b0;
      ld2       <= ld1;
      if (ld2) tx_byte <= mbox ? rsp_q : mem_q;
      if (byte_v) begin
        case (state)
          ST_OPCODE: begin
            case (rx_byte)
              OP_WRITE: begin
                state    <= ST_ADDR_HI;
                wr_frame <= 1'b1;
              end
              OP_READ:   state <= ST_ADDR_HI;
              OP_STATUS: begin
                state   <= ST_STATUS;
                tx_byte <= status_byte;
              end
              OP_WREN: begin
                wel   <= 1'b1;
                state <= ST_HOLD;
              end
              default:   state <= ST_MUTE;
            endcase
          end
          ST_ADDR_HI: begin
            addr[15:8] <= rx_byte;
            state      <= ST_ADDR_LO;
          end
          ST_ADDR_LO: begin
            addr  <= {addr[15:8], rx_byte};
            mbox  <= ({addr[15:8], rx_byte} == MBOX_ADDR);
            state <= wr_frame ? ST_WRITE : ST_READ;
            ld1   <= !wr_frame;
          end
          ST_WRITE: begin
            if (wel) begin
              if (mbox) begin
                buf_ptr   <= buf_ptr + PTR_ONE;
                cmd_dirty <= 1'b1;
              end else begin
                addr <= addr + 16'd1;
              end
            end
          end
          ST_READ: begin
            if (mbox) buf_ptr <= buf_ptr + PTR_ONE;
            else      addr    <= addr + 16'd1;
            ld1 <= 1'b1;
          end
          ST_STATUS: tx_byte <= status_byte;
          default: ;
        endcase
      end
      if (frame_end) begin
        state     <= ST_OPCODE;
        buf_ptr   <= '0;
        mbox      <= 1'b0;
        wr_frame  <= 1'b0;
        cmd_dirty <= 1'b0;
        cmd_ready <= cmd_dirty;
        if (wr_frame) wel <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spi_mailbox_chk.sv
module spi_mailbox_chk #(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n_s,
  input logic          so_oe,
  input logic          in_mute,
  input logic          cmd_ready,
  input logic          cmd_we,
  input logic          mem_we,
  input logic [15:0]   addr,
  input logic          frame_end,
  input logic [PW-1:0] buf_ptr
);

  a_r3_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
    (cs_n_s && $past(cs_n_s)) |-> !so_oe);

  a_r4_mute_silent: assert property (@(posedge clk) disable iff (rst)
    in_mute |-> !so_oe);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |=> !cmd_ready);

  a_r8_mbox_steer: assert property (@(posedge clk) disable iff (rst)
    cmd_we |-> !mem_we);

  a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (addr == $past(addr) + 16'd1));

  a_r10_ptr_restart: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (buf_ptr == '0));

endmodule

bind spi_mailbox spi_mailbox_chk #(.PW(BUF_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n_s    (cs_n_s),
  .so_oe     (so_oe),
  .in_mute   (state == spi_mailbox_pkg::ST_MUTE),
  .cmd_ready (cmd_ready),
  .cmd_we    (cmd_we),
  .mem_we    (mem_we),
  .addr      (addr),
  .frame_end (frame_end),
  .buf_ptr   (buf_ptr)
);

// File: tb/test_spi_mailbox.sv
`timescale 1ns/1ps
module test_spi_mailbox;

  localparam int BUF_AW = 4;
  localparam int HALF   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic so_d, so_oe, cmd_ready;
  logic [BUF_AW-1:0] cmd_raddr = '0;
  logic [7:0] cmd_rdata;
  logic rsp_we = 1'b0;
  logic [BUF_AW-1:0] rsp_waddr = '0;
  logic [7:0] rsp_wdata = '0;
  logic rsp_ready = 1'b0;

  int n_checks = 0;
  int n_err = 0;
  int pulses = 0;
  int pulse_cycles = 0;
  logic rdy_q = 1'b0;

  always #2.5 clk = ~clk;

  spi_mailbox #(.BUF_AW(BUF_AW)) i_spi_mailbox (
    .clk (clk), .rst (rst), .sck (sck), .cs_n (cs_n), .si (si),
    .so_d (so_d), .so_oe (so_oe), .cmd_ready (cmd_ready),
    .cmd_raddr (cmd_raddr), .cmd_rdata (cmd_rdata),
    .rsp_we (rsp_we), .rsp_waddr (rsp_waddr), .rsp_wdata (rsp_wdata),
    .rsp_ready (rsp_ready)
  );

  always @(posedge clk) begin
    rdy_q <= cmd_ready;
    if (!rst && cmd_ready) begin
      pulse_cycles <= pulse_cycles + 1;
      if (!rdy_q) pulses <= pulses + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  task automatic cs_low(input bit m3);
    sck = m3;
    tick(4);
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_high;
    tick(HALF);
    cs_n = 1'b1;
    tick(8);
  endtask

  task automatic xfer(input bit m3, input logic [7:0] tx, input int nbits,
                      output logic [7:0] rx, output bit oe_any, output bit oe_all);
    rx = '0;
    oe_any = 1'b0;
    oe_all = 1'b1;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (m3) sck = 1'b0;
      si = tx[i];
      tick(HALF);
      rx[i] = so_d;
      if (so_oe) oe_any = 1'b1;
      else       oe_all = 1'b0;
      sck = 1'b1;
      tick(HALF);
      if (!m3) sck = 1'b0;
    end
  endtask

  // header = opcode plus optional address; returns whether SO was ever enabled
  task automatic send_hdr(input bit m3, input logic [7:0] op, input bit with_addr,
                          input logic [15:0] a, output bit hdr_oe);
    logic [7:0] rx;
    bit any, all;
    hdr_oe = 1'b0;
    xfer(m3, op, 8, rx, any, all);
    hdr_oe |= any;
    if (with_addr) begin
      xfer(m3, a[15:8], 8, rx, any, all);
      hdr_oe |= any;
      xfer(m3, a[7:0], 8, rx, any, all);
      hdr_oe |= any;
    end
  endtask

  task automatic wren(input bit m3);
    bit h;
    cs_low(m3);
    send_hdr(m3, 8'h06, 1'b0, 16'h0, h);
    cs_high();
  endtask

  task automatic write_frame(input bit m3, input logic [15:0] a,
                             input logic [23:0] d, input int n);
    logic [7:0] rx;
    bit h, any, all;
    cs_low(m3);
    send_hdr(m3, 8'h02, 1'b1, a, h);
    for (int i = 0; i < n; i++) xfer(m3, d[23-8*i -: 8], 8, rx, any, all);
    cs_high();
  endtask

  task automatic read_frame(input bit m3, input logic [15:0] a, input int n,
                            output logic [23:0] d, output bit hdr_oe, output bit data_oe);
    logic [7:0] rx;
    bit any, all;
    d = '0;
    data_oe = 1'b1;
    cs_low(m3);
    send_hdr(m3, 8'h03, 1'b1, a, hdr_oe);
    for (int i = 0; i < n; i++) begin
      xfer(m3, 8'h00, 8, rx, any, all);
      d[23-8*i -: 8] = rx;
      data_oe &= all;
    end
    cs_high();
  endtask

  task automatic status_frame(input bit m3, input int n, output logic [7:0] st,
                              output bit ok_repeat);
    logic [7:0] rx;
    bit h, any, all;
    cs_low(m3);
    send_hdr(m3, 8'h05, 1'b0, 16'h0, h);
    ok_repeat = !h;
    st = '0;
    for (int i = 0; i < n; i++) begin
      xfer(m3, 8'h00, 8, rx, any, all);
      if (i == 0) st = rx;
      else if (rx != st) ok_repeat = 1'b0;
      if (!all) ok_repeat = 1'b0;
    end
    cs_high();
  endtask

  task automatic t_reset;
    logic [7:0] st;
    bit ok;
    check(so_oe == 1'b0, "R12 so_oe after reset", so_oe, 0);
    check(cmd_ready == 1'b0, "R12 cmd_ready after reset", cmd_ready, 0);
    status_frame(1'b0, 2, st, ok);
    check(st == 8'h00, "R12 R7 status after reset", st, 8'h00);
    check(ok, "R3 R7 status driven on every bit and repeated", ok, 1);
  endtask

  task automatic t_modes;
    logic [23:0] d;
    bit h, o;
    wren(1'b0);
    write_frame(1'b0, 16'h0010, 24'h112233, 3);
    read_frame(1'b1, 16'h0010, 3, d, h, o);
    check(d == 24'h112233, "R1 R2 R5 mode0 write, mode3 read", d, 24'h112233);
    check(!h && o, "R3 oe low in header, high in data", {h, o}, 2'b01);
    read_frame(1'b0, 16'h0011, 2, d, h, o);
    check(d[23:8] == 16'h2233, "R1 R5 mode0 read from offset", d[23:8], 16'h2233);
    check(so_oe == 1'b0, "R3 oe low after frame", so_oe, 0);
  endtask

  task automatic t_wel;
    logic [7:0] st;
    logic [23:0] d;
    bit ok, h, o;
    status_frame(1'b1, 1, st, ok);
    check(st == 8'h00, "R6 latch cleared by write frame", st, 8'h00);
    write_frame(1'b1, 16'h0010, 24'h990000, 1);
    read_frame(1'b0, 16'h0010, 1, d, h, o);
    check(d[23:16] == 8'h11, "R6 write without enable ignored", d[23:16], 8'h11);
    wren(1'b1);
    status_frame(1'b1, 1, st, ok);
    check(st == 8'h02, "R7 status bit1 shows latch", st, 8'h02);
    rsp_ready = 1'b1;
    status_frame(1'b0, 1, st, ok);
    check(st == 8'h03, "R7 status bit0 shows response ready", st, 8'h03);
    rsp_ready = 1'b0;
  endtask

  task automatic t_bad_opcode;
    logic [7:0] rx, st;
    logic [23:0] d;
    bit any, all, seen, ok, h, o;
    seen = 1'b0;
    cs_low(1'b0);
    xfer(1'b0, 8'h7A, 8, rx, any, all);
    seen |= any;
    xfer(1'b0, 8'h02, 8, rx, any, all);
    seen |= any;
    xfer(1'b0, 8'h00, 8, rx, any, all);
    seen |= any;
    xfer(1'b0, 8'h10, 8, rx, any, all);
    seen |= any;
    xfer(1'b0, 8'h55, 8, rx, any, all);
    seen |= any;
    cs_high();
    check(!seen, "R4 so_oe stays low after unknown code", seen, 0);
    read_frame(1'b1, 16'h0010, 1, d, h, o);
    check(d[23:16] == 8'h11, "R4 bytes after unknown code ignored", d[23:16], 8'h11);
    status_frame(1'b1, 1, st, ok);
    check(st == 8'h02, "R4 latch untouched by ignored frame", st, 8'h02);
  endtask

  task automatic t_mbox_write;
    logic [23:0] d;
    bit h, o;
    check(pulses == 0, "R9 no pulse for non-command frames", pulses, 0);
    write_frame(1'b0, 16'h0000, 24'h5A0000, 1);
    check(pulses == 0, "R9 no pulse for memory write", pulses, 0);
    wren(1'b0);
    write_frame(1'b0, 16'hFE00, 24'hC1C2C3, 3);
    check(pulses == 1, "R9 one pulse after command frame", pulses, 1);
    check(pulse_cycles == 1, "R9 pulse lasts one clock", pulse_cycles, 1);
    for (int i = 0; i < 3; i++) begin
      cmd_raddr = BUF_AW'(i);
      tick(2);
      check(cmd_rdata == 8'hC1 + 8'(i), "R8 command buffer contents", cmd_rdata, 8'hC1 + 8'(i));
    end
    read_frame(1'b0, 16'h0000, 1, d, h, o);
    check(d[23:16] == 8'h5A, "R8 aliased memory untouched", d[23:16], 8'h5A);
  endtask

  task automatic t_mbox_read;
    logic [23:0] d;
    bit h, o;
    for (int i = 0; i < 3; i++) begin
      rsp_we = 1'b1;
      rsp_waddr = BUF_AW'(i);
      rsp_wdata = 8'hD1 + 8'(i);
      tick(1);
    end
    rsp_we = 1'b0;
    tick(2);
    read_frame(1'b1, 16'hFE00, 3, d, h, o);
    check(d == 24'hD1D2D3, "R10 response buffer read", d, 24'hD1D2D3);
    check(o, "R3 oe during mailbox read", o, 1);
    read_frame(1'b0, 16'hFE00, 1, d, h, o);
    check(d[23:16] == 8'hD1, "R10 pointer restarts each frame", d[23:16], 8'hD1);
  endtask

  task automatic t_abort;
    logic [7:0] rx, st;
    logic [23:0] d;
    bit h, any, all, ok, o;
    wren(1'b0);
    cs_low(1'b0);
    send_hdr(1'b0, 8'h02, 1'b1, 16'h0010, h);
    xfer(1'b0, 8'hA0, 4, rx, any, all);
    cs_high();
    read_frame(1'b0, 16'h0010, 2, d, h, o);
    check(d[23:8] == 16'h1122, "R11 partial byte discarded", d[23:8], 16'h1122);
    cs_low(1'b1);
    xfer(1'b1, 8'h00, 3, rx, any, all);
    cs_high();
    status_frame(1'b1, 1, st, ok);
    check(st == 8'h00, "R11 R6 fresh decode after abort", st, 8'h00);
    check(pulses == 1, "R9 no extra pulses", pulses, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_modes();
    t_wel();
    t_bad_opcode();
    t_mbox_write();
    t_mbox_read();
    t_abort();
    finish_run();
  end

endmodule